// File: doc/BRIEF.md
# Synchronous Bus Memory and Port Responder

This block answers a small 8-bit processor bus that uses a single-clock synchronous protocol with no handshake. One enable strobe qualifies each access. The read, write, IO and instruction-fetch qualifiers mean something only in a cycle where the strobe is high. When the strobe is high, the block samples the address and write data on the rising edge that ends that cycle. A memory access goes to an internal byte array. An IO access goes to a small bank of port registers.

Read data is registered on that same edge, so it is stable for the whole following cycle. The requester samples it on the next rising edge. Between reads the read data output keeps its last value. A cycle that asserts a write together with a read or a fetch is a protocol error. In that case the write is dropped, the read is still served, and a one-cycle error flag follows. Reset is synchronous and active high. It clears the array, the ports and both outputs.

The data paths follow the bus timing directly. They carry no back-pressure: the requester may issue an access in any cycle, and each read result is due exactly one cycle later.

Top module: `bus_responder`

## Requirements
- R1: After a synchronous reset, `bus_rdata` is 0x00 and `bus_err` is 0. Every memory byte and every port register reads back 0x00 until it is written.
- R2: When `bus_en`=1, `bus_wr`=1, `bus_rd`=0, `bus_fetch`=0 and `bus_io`=0 in a cycle, `bus_wdata` is stored at memory byte `bus_addr[7:0]` on the rising edge that ends that cycle.
- R3: A memory read puts the addressed byte on `bus_rdata` from the edge that ends the strobe cycle until the next read completes. A memory read is `bus_en`=1 with `bus_rd`=1 and `bus_io`=0. A write in an earlier cycle, including the cycle just before, is visible to the read.
- R4: Memory decoding uses only `bus_addr[7:0]`. Addresses that differ only in bits 15:8 reach the same byte.
- R5: An IO write is `bus_en`=1, `bus_wr`=1, `bus_io`=1, with `bus_rd`=0 and `bus_fetch`=0. It stores `bus_wdata` into port register `bus_addr[2:0]`. An IO read is `bus_en`=1, `bus_rd`=1, `bus_io`=1 and `bus_fetch`=0. It returns that register with read timing R3. IO accesses never touch the memory array, and memory accesses never touch the ports.
- R6: Port decoding uses only `bus_addr[2:0]`. Address bits 15:3 do not affect an IO access.
- R7: When `bus_en`=0, the values of `bus_rd`, `bus_wr`, `bus_io`, `bus_fetch`, `bus_addr` and `bus_wdata` have no effect. No stored byte changes, `bus_rdata` holds, and `bus_err` is 0 in the next cycle.
- R8: A strobed cycle with `bus_wr`=1 together with `bus_rd`=1 or `bus_fetch`=1 is a protocol error. The write is suppressed, the read is still served, and `bus_err` is 1 for exactly the following cycle. `bus_err` is 0 after any other cycle.
- R9: A strobed cycle with `bus_fetch`=1 and `bus_wr`=0 is a memory read at `bus_addr[7:0]`. This holds whatever `bus_rd` and `bus_io` are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 16 | Access address, valid with `bus_en` |
| bus_en | input | 1 | Access strobe qualifying all other bus inputs |
| bus_rd | input | 1 | Read qualifier |
| bus_wr | input | 1 | Write qualifier |
| bus_io | input | 1 | Selects the port bank instead of memory |
| bus_fetch | input | 1 | Instruction fetch, treated as a memory read |
| bus_wdata | input | 8 | Write data, valid with `bus_en` |
| bus_rdata | output | 8 | Registered read data, held between reads |
| bus_err | output | 1 | One-cycle flag after a read/write conflict |

## Verification
The bench builds the block with its default parameters: 16 address bits, 8 data bits, a 256-byte array and 8 ports. With these values every array byte and every port index can be reached from ordinary bus addresses. The upper address byte and address bits 7:3 are then spare for alias checks on memory and IO. A pseudo-random stream of mixed reads and writes, with idle gaps and back-to-back turnarounds, runs against a shadow copy of the array and ports. A second reset halfway through shows that the whole array clears again.

// File: rtl/bus_resp_pkg.sv
package bus_resp_pkg;

  typedef struct packed {
    logic mem_wr;
    logic mem_rd;
    logic io_wr;
    logic io_rd;
    logic conflict;
  } bus_op_t;

endpackage

// File: rtl/bus_resp_decode.sv
module bus_resp_decode
  import bus_resp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int MEM_AW  = 8,
  parameter int PORT_AW = 3
) (
  input  logic [ADDR_W-1:0]  addr,
  input  logic               en,
  input  logic               rd,
  input  logic               wr,
  input  logic               io,
  input  logic               fetch,
  output bus_op_t            op,
  output logic [MEM_AW-1:0]  mem_idx,
  output logic [PORT_AW-1:0] port_idx
);

  logic rd_like;
  logic unused_hi;

  // a fetch reads memory regardless of the other qualifiers
  assign rd_like     = rd | fetch;
  assign op.conflict = en & wr & rd_like;
  assign op.mem_rd   = en & (fetch | (rd & ~io));
  assign op.io_rd    = en & rd & io & ~fetch;
  assign op.mem_wr   = en & wr & ~rd_like & ~io;
  assign op.io_wr    = en & wr & ~rd_like & io;

  assign mem_idx  = addr[MEM_AW-1:0];
  assign port_idx = addr[PORT_AW-1:0];

  // upper address bits take no part in decoding
  assign unused_hi = ^addr[ADDR_W-1:MEM_AW];

endmodule

// File: rtl/bus_resp_mem.sv
module bus_resp_mem #(
  parameter int AW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] arr [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) arr[i] <= '0;
    end else if (we) begin
      arr[idx] <= wdata;
    end
  end

  assign rdata = arr[idx];

endmodule

// File: rtl/bus_resp_ports.sv
module bus_resp_ports #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  localparam int NPORT = 1 << AW;

  logic [NPORT-1:0][DW-1:0] port_q;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    always_ff @(posedge clk) begin
      if (rst) begin
        port_q[g] <= '0;
      end else if (we && (idx == AW'(g))) begin
        port_q[g] <= wdata;
      end
    end
  end

  assign rdata = port_q[idx];

endmodule

// File: rtl/bus_responder.sv
module bus_responder
  import bus_resp_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int MEM_AW  = 8,
  parameter int PORT_AW = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_en,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic              bus_io,
  input  logic              bus_fetch,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              bus_err
);

  bus_op_t            op;
  logic [MEM_AW-1:0]  mem_idx;
  logic [PORT_AW-1:0] port_idx;
  logic [DATA_W-1:0]  mem_dout;
  logic [DATA_W-1:0]  port_dout;
  logic [DATA_W-1:0]  rdata_q;
  logic               err_q;

  bus_resp_decode #(
    .ADDR_W (ADDR_W),
    .MEM_AW (MEM_AW),
    .PORT_AW(PORT_AW)
  ) u_dec (
    .addr    (bus_addr),
    .en      (bus_en),
    .rd      (bus_rd),
    .wr      (bus_wr),
    .io      (bus_io),
    .fetch   (bus_fetch),
    .op      (op),
    .mem_idx (mem_idx),
    .port_idx(port_idx)
  );

  bus_resp_mem #(
    .AW(MEM_AW),
    .DW(DATA_W)
  ) u_mem (
    .clk  (clk),
    .rst  (rst),
    .we   (op.mem_wr),
    .idx  (mem_idx),
    .wdata(bus_wdata),
    .rdata(mem_dout)
  );

  bus_resp_ports #(
    .AW(PORT_AW),
    .DW(DATA_W)
  ) u_ports (
    .clk  (clk),
    .rst  (rst),
    .we   (op.io_wr),
    .idx  (port_idx),
    .wdata(bus_wdata),
    .rdata(port_dout)
  );

  // read data lands on the edge closing the strobe cycle and holds until the next read
  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      err_q <= op.conflict;
      if (op.mem_rd) begin
        rdata_q <= mem_dout;
      end else if (op.io_rd) begin
        rdata_q <= port_dout;
      end
    end
  end

  assign bus_rdata = rdata_q;
  assign bus_err   = err_q;

endmodule

// File: rtl/bus_responder_chk.sv
module bus_responder_chk #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_en,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic              bus_io,
  input logic              bus_fetch,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              bus_err
);

  logic unused_chk;
  assign unused_chk = ^{bus_addr, bus_io, bus_wdata};

  // R1
  reset_value_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (bus_rdata == '0 && !bus_err));

  // R8
  conflict_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_en && bus_wr && (bus_rd || bus_fetch)) |=> bus_err);

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (rst)
    bus_err |-> $past(bus_en && bus_wr && (bus_rd || bus_fetch)));

  // R3
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(bus_en && (bus_rd || bus_fetch)) |=> $stable(bus_rdata));

  // R7
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_en |=> !bus_err);

endmodule

bind bus_responder bus_responder_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_bus_responder.sv
`timescale 1ns/1ps
module tb_bus_responder;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_en = 1'b0, bus_rd = 1'b0, bus_wr = 1'b0, bus_io = 1'b0, bus_fetch = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        bus_err;

  always #5 clk = ~clk;

  bus_responder dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_en(bus_en),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_io(bus_io), .bus_fetch(bus_fetch),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err)
  );

  typedef struct {
    int         due;
    logic [7:0] d;
    logic       e;
    string      tag;
  } item_t;

  item_t      sb[$];
  int         cyc = 0;
  int         checks = 0;
  int         fails = 0;
  bit         done = 0;
  logic [7:0] sh_mem [256];
  logic [7:0] sh_port [8];
  logic [7:0] exp_rd = '0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare outputs against queued expectations
  always @(negedge clk) begin
    item_t it;
    while (sb.size() > 0 && sb[0].due == cyc) begin
      it = sb.pop_front();
      checks++;
      if (bus_rdata !== it.d || bus_err !== it.e) begin
        fails++;
        $display("FAIL %s: rdata=%h err=%b expected rdata=%h err=%b",
                 it.tag, bus_rdata, bus_err, it.d, it.e);
      end
    end
  end

  task automatic drive(input logic en, input logic rd, input logic wr, input logic io,
                       input logic fe, input logic [15:0] a, input logic [7:0] d,
                       input string tag);
    item_t it;
    logic conflict;
    @(negedge clk);
    bus_en = en; bus_rd = rd; bus_wr = wr; bus_io = io; bus_fetch = fe;
    bus_addr = a; bus_wdata = d;
    conflict = en && wr && (rd || fe);
    if (en && (fe || (rd && !io))) exp_rd = sh_mem[a[7:0]];
    else if (en && rd && io) exp_rd = sh_port[a[2:0]];
    if (en && wr && !conflict) begin
      if (io) sh_port[a[2:0]] = d;
      else sh_mem[a[7:0]] = d;
    end
    it.due = cyc + 1; it.d = exp_rd; it.e = conflict; it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic mwr(input logic [15:0] a, input logic [7:0] d, input string tag);
    drive(1, 0, 1, 0, 0, a, d, tag);
  endtask
  task automatic mrd(input logic [15:0] a, input string tag);
    drive(1, 1, 0, 0, 0, a, 8'h00, tag);
  endtask
  task automatic iowr(input logic [15:0] a, input logic [7:0] d, input string tag);
    drive(1, 0, 1, 1, 0, a, d, tag);
  endtask
  task automatic iord(input logic [15:0] a, input string tag);
    drive(1, 1, 0, 1, 0, a, 8'h00, tag);
  endtask
  task automatic idle(input string tag);
    drive(0, 0, 0, 0, 0, 16'h0000, 8'h00, tag);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; bus_en = 1'b0; bus_rd = 1'b0; bus_wr = 1'b0; bus_io = 1'b0; bus_fetch = 1'b0;
    repeat (2) @(negedge clk);
    for (int i = 0; i < 256; i++) sh_mem[i] = 8'h00;
    for (int i = 0; i < 8; i++) sh_port[i] = 8'h00;
    exp_rd = 8'h00;
    rst = 1'b0;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    do_reset();
    // R1 reset state
    idle("R1 outputs after reset");
    mrd(16'h0000, "R1 mem[00] zero");
    mrd(16'h00FF, "R1 mem[FF] zero");
    iord(16'h0005, "R1 port5 zero");

    // R2 / R3 writes then reads
    mwr(16'h0010, 8'hA5, "R2 write 10");
    mwr(16'h0011, 8'h3C, "R2 write 11");
    idle("R3 hold after writes");
    mrd(16'h0010, "R3 read 10");
    idle("R3 hold idle");
    idle("R3 hold idle 2");
    mrd(16'h0011, "R3 read 11");
    mwr(16'h0080, 8'h7E, "R3 turnaround write");
    mrd(16'h0080, "R3 read just after write");

    // R4 aliasing on upper byte
    mwr(16'h1234, 8'h5A, "R4 write 1234");
    mrd(16'h5634, "R4 alias 5634");
    mrd(16'h0034, "R4 alias 0034");

    // R5 IO ports distinct from memory
    for (int i = 0; i < 8; i++) iowr(16'(i), 8'(8'hC0 + i), "R5 port write");
    for (int i = 0; i < 8; i++) iord(16'(i), "R5 port read");
    mrd(16'h0003, "R5 memory untouched by IO");
    mwr(16'h0002, 8'h99, "R5 mem write low addr");
    iord(16'h0002, "R5 port untouched by memory");

    // R6 IO alias
    iord(16'h00F9, "R6 alias port1 via F9");
    iowr(16'hAB2E, 8'h44, "R6 write port6 via AB2E");
    iord(16'h0006, "R6 read port6");

    // R7 strobe low has no effect
    drive(0, 0, 1, 0, 0, 16'h0010, 8'hEE, "R7 unstrobed write");
    drive(0, 0, 1, 1, 0, 16'h0001, 8'hEE, "R7 unstrobed io write");
    drive(0, 1, 1, 0, 1, 16'h0011, 8'hEE, "R7 unstrobed conflict");
    mrd(16'h0010, "R7 mem unchanged");
    iord(16'h0001, "R7 port unchanged");

    // R8 conflict
    drive(1, 1, 1, 0, 0, 16'h0011, 8'h00, "R8 rd+wr conflict");
    idle("R8 err clears");
    mrd(16'h0011, "R8 write suppressed");
    drive(1, 0, 1, 1, 1, 16'h0004, 8'h12, "R8 fetch+wr conflict");
    iord(16'h0004, "R8 io write suppressed");

    // R9 fetch reads memory
    drive(1, 0, 0, 0, 1, 16'h0080, 8'h00, "R9 fetch read");
    drive(1, 1, 0, 1, 1, 16'h0010, 8'h00, "R9 fetch with io reads memory");

    // mixed stream
    lfsr = 16'hACE1;
    for (int n = 0; n < 400; n++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      case (lfsr[2:0])
        3'd0, 3'd1: mwr({lfsr[15:8], lfsr[10:3]}, lfsr[7:0] ^ lfsr[15:8], "R2 stream write");
        3'd2, 3'd3: mrd({lfsr[3:0], lfsr[11:4]}, "R3 stream read");
        3'd4:       iowr({8'h00, lfsr[12:5]}, lfsr[15:8], "R5 stream io write");
        3'd5:       iord({lfsr[7:0], lfsr[15:8]}, "R6 stream io read");
        3'd6:       drive(1, 1, 1, lfsr[9], 0, {8'h00, lfsr[14:7]}, lfsr[7:0], "R8 stream conflict");
        default:    idle("R7 stream idle");
      endcase
    end

    // R1 second reset clears the array
    do_reset();
    mrd(16'h0010, "R1 mem cleared by reset");
    mrd(16'h0080, "R1 mem cleared by reset");
    iord(16'h0006, "R1 port cleared by reset");
    idle("R1 final hold");
    repeat (2) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule